// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a stuck two-wire bus when the controller beside it asks for it. A target left in the middle of a byte can keep SDA low forever. The sequencer then clocks SCL, one low phase and one high phase per pulse, and tests SDA near the end of each high phase. The first time SDA reads high, pulsing stops and a STOP condition puts the bus back to idle. If SDA is still low after the configured number of pulses, the sequencer finishes anyway. In that case the line status shows that the bus is still held.

A command can arrive while SDA is already high but SCL is low. The sequencer then only generates a STOP condition. If both lines are already high, it finishes without touching them. Every finish sets a sticky done flag, which the controller clears. Phase timing comes from a one-cycle `sclTick` strobe that the surrounding controller supplies. Both lines are driven open-drain: each output asks for the line to be pulled low, and releasing it lets the line float high.

Top module: `bus_recovery_seq`

## Requirements
- R1: A `recoverCmd` pulse that arrives while the sequencer is idle and sees SDA low makes it pull SCL low from the next cycle. Each low or high phase then lasts until the next `sclTick`.
- R2: SDA is sampled when the `sclTick` ends each SCL high phase, and pulsing stops on the first high sample. A target that releases SDA after its Nth SCL falling edge therefore sees exactly N pulses, for 1 <= N <= MAX_PULSES (default 8).
- R3: If SDA is still low after MAX_PULSES pulses, the sequencer finishes with exactly MAX_PULSES SCL rising edges. It generates no STOP, sets `recoverDone`, and `sdaLevel` then reads 0.
- R4: After a successful pulse sequence the sequencer produces exactly one STOP. SCL is pulled low first, then SDA is pulled low, then SCL is released, and then SDA is released while SCL is high. The block never produces a START, meaning an SDA fall while SCL is high.
- R5: A command that sees SDA high and SCL low produces no pulse and only the STOP sequence, which gives one SCL rising edge and one STOP.
- R6: A command that sees both lines high leaves both pull outputs inactive and sets `recoverDone`.
- R7: `recoverDone` stays at 1 until a `doneClr` pulse, which clears it in the next cycle. A set in the same cycle wins over the clear.
- R8: `sclLevel` and `sdaLevel` are the line levels registered once. `busBusy` is 1 while a sequence runs or while either registered level is 0.
- R9: A `recoverCmd` that arrives while a sequence runs is ignored: the pulse count and the STOP count are those of the undisturbed sequence.
- R10: After reset neither line is pulled, `recoverDone` is 0 and `busBusy` is 0. Outside a sequence no line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclTick | input | 1 | One-cycle strobe that ends each SCL phase |
| recoverCmd | input | 1 | One-cycle request to start recovery |
| doneClr | input | 1 | One-cycle clear of the done flag |
| sclIn | input | 1 | Observed SCL level |
| sdaIn | input | 1 | Observed SDA level |
| sclPullLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| recoverDone | output | 1 | Sticky completion flag |
| sclLevel | output | 1 | Registered SCL level |
| sdaLevel | output | 1 | Registered SDA level |
| busBusy | output | 1 | Sequence running or a line low |

## Verification
The case that is hardest to reach from the ports is SDA becoming free at exactly the right pulse. Reaching it needs a target that reacts to the block's own SCL edges. The bench therefore models an open-drain bus with a target that counts SCL falling edges and releases SDA after a chosen count N. Random N values around the pulse limit cover early release, release on the last allowed pulse and failure. Directed trials add a command issued in the middle of a sequence and an SCL line held low by another device at the moment of the command.

// File: rtl/bus_recovery_pkg.sv
package bus_recovery_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_STOP_PREP,
    ST_STOP_SETUP,
    ST_STOP_HOLD,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic setDone;
  } dpStrobe_t;

endpackage

// File: rtl/bus_recovery_ctrl.sv
module bus_recovery_ctrl
  import bus_recovery_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclTick,
  input  logic      recoverCmd,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      cntAtMax,
  output dpStrobe_t strobe,
  output logic      sclPullLow,
  output logic      sdaPullLow,
  output logic      seqActive
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (recoverCmd) begin
          strobe.cntClr = 1'b1;
          if (!sdaIn)      stateNext = ST_PULSE_LO;
          else if (!sclIn) stateNext = ST_STOP_PREP;
          else             stateNext = ST_FINISH;
        end
      end
      ST_PULSE_LO: begin
        if (sclTick) begin
          strobe.cntInc = 1'b1;
          stateNext     = ST_PULSE_HI;
        end
      end
      ST_PULSE_HI: begin
        if (sclTick) begin
          if (sdaIn)         stateNext = ST_STOP_PREP;
          else if (cntAtMax) stateNext = ST_FINISH;
          else               stateNext = ST_PULSE_LO;
        end
      end
      ST_STOP_PREP:  if (sclTick) stateNext = ST_STOP_SETUP;
      ST_STOP_SETUP: if (sclTick) stateNext = ST_STOP_HOLD;
      ST_STOP_HOLD:  if (sclTick) stateNext = ST_FINISH;
      ST_FINISH: begin
        strobe.setDone = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // line drives decoded from the registered state only
  always_comb begin
    sclPullLow = (state == ST_PULSE_LO) || (state == ST_STOP_PREP) ||
                 (state == ST_STOP_SETUP);
    sdaPullLow = (state == ST_STOP_SETUP) || (state == ST_STOP_HOLD);
    seqActive  = (state != ST_IDLE);
  end

endmodule

// File: rtl/bus_recovery_dp.sv
module bus_recovery_dp
  import bus_recovery_pkg::*;
#(
  parameter int MAX_PULSES = 8,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          doneClr,
  input  logic          seqActive,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          cntAtMax,
  output logic [CW-1:0] pulseCount,
  output logic          recoverDone,
  output logic          sclLevel,
  output logic          sdaLevel,
  output logic          busBusy
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCount <= '0;
    else if (strobe.cntClr) pulseCount <= '0;
    else if (strobe.cntInc) pulseCount <= pulseCount + 1'b1;
  end

  assign cntAtMax = (pulseCount == CW'(MAX_PULSES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               recoverDone <= 1'b0;
    else if (strobe.setDone) recoverDone <= 1'b1;
    else if (doneClr)        recoverDone <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLevel <= 1'b1;
      sdaLevel <= 1'b1;
    end else begin
      sclLevel <= sclIn;
      sdaLevel <= sdaIn;
    end
  end

  assign busBusy = seqActive || !sclLevel || !sdaLevel;

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
  import bus_recovery_pkg::*;
#(
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclTick,
  input  logic recoverCmd,
  input  logic doneClr,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclPullLow,
  output logic sdaPullLow,
  output logic recoverDone,
  output logic sclLevel,
  output logic sdaLevel,
  output logic busBusy
);

  localparam int CW = $clog2(MAX_PULSES + 1);

  dpStrobe_t     strobe;
  logic          cntAtMax;
  logic          seqActive;
  logic          setDoneW;
  logic [CW-1:0] pulseCount;

  assign setDoneW = strobe.setDone;

  bus_recovery_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclTick    (sclTick),
    .recoverCmd (recoverCmd),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .cntAtMax   (cntAtMax),
    .strobe     (strobe),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow),
    .seqActive  (seqActive)
  );

  bus_recovery_dp #(.MAX_PULSES(MAX_PULSES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .doneClr     (doneClr),
    .seqActive   (seqActive),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .cntAtMax    (cntAtMax),
    .pulseCount  (pulseCount),
    .recoverDone (recoverDone),
    .sclLevel    (sclLevel),
    .sdaLevel    (sdaLevel),
    .busBusy     (busBusy)
  );

endmodule

// File: rtl/bus_recovery_chk.sv
module bus_recovery_chk #(
  parameter int MAX_PULSES = 8,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclPullLow,
  input logic          sdaPullLow,
  input logic          recoverDone,
  input logic          doneClr,
  input logic          setDone,
  input logic          seqActive,
  input logic [CW-1:0] pulseCount
);

  // R4
  no_false_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> sclPullLow);

  // R4
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclPullLow);

  // R2
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCount <= CW'(MAX_PULSES));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !setDone) |=> !recoverDone);

  // R6
  done_after_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recoverDone) |-> $past(seqActive));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seqActive |-> (!sclPullLow && !sdaPullLow));

endmodule

bind bus_recovery_seq bus_recovery_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sclPullLow  (sclPullLow),
  .sdaPullLow  (sdaPullLow),
  .recoverDone (recoverDone),
  .doneClr     (doneClr),
  .setDone     (setDoneW),
  .seqActive   (seqActive),
  .pulseCount  (pulseCount)
);

// File: tb/bus_recovery_seq_tb_top.sv
`timescale 1ns/1ps
module bus_recovery_seq_tb_top;

  localparam int MAX_PULSES = 8;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclTick = 1'b0;
  logic recoverCmd = 1'b0;
  logic doneClr = 1'b0;
  logic sclPullLow, sdaPullLow, recoverDone, sclLevel, sdaLevel, busBusy;
  logic sclIn, sdaIn;

  // bus model: other device can hold SCL, target can hold SDA
  logic extScl = 1'b0;
  logic tgtArmed = 1'b0;
  int   tgtN = 0;
  int   tgtFalls = 0;
  int   tgtBase = 0;
  logic tgtSda;

  assign tgtSda = tgtArmed && ((tgtFalls - tgtBase) < tgtN);
  assign sclIn  = !(sclPullLow || extScl);
  assign sdaIn  = !(sdaPullLow || tgtSda);

  int rises = 0, stops = 0, starts = 0;
  int nChecks = 0, nFail = 0;
  int tickCnt = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickCnt <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
    sclTick <= (tickCnt == TICK_DIV - 1);
  end

  always @(negedge sclIn) if (tgtArmed) tgtFalls++;
  always @(posedge sclIn) rises++;
  always @(posedge sdaIn) if (sclIn) stops++;
  always @(negedge sdaIn) if (sclIn) starts++;

  bus_recovery_seq #(.MAX_PULSES(MAX_PULSES)) dut_i (
    .clk(clk), .rstN(rstN), .sclTick(sclTick), .recoverCmd(recoverCmd),
    .doneClr(doneClr), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .recoverDone(recoverDone), .sclLevel(sclLevel), .sdaLevel(sdaLevel),
    .busBusy(busBusy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // expected SCL rising edges, from R2..R6
  function automatic int expRises(input int kind, input int n);
    if (kind == 2) return 0;
    if (kind == 1) return 1;
    if (n <= MAX_PULSES) return n + 1;
    return MAX_PULSES;
  endfunction

  function automatic bit expSuccess(input int kind, input int n);
    return (kind != 0) || (n <= MAX_PULSES);
  endfunction

  // kind 0: target holds SDA for n falls; 1: SCL held by other device; 2: idle bus
  task automatic runTrial(input int kind, input int n, input bit extraCmd);
    int r0, s0, st0, w;
    bit ok;
    tgtBase  = tgtFalls;
    tgtN     = n;
    tgtArmed = (kind == 0);
    extScl   = (kind == 1);
    repeat (2) @(negedge clk);
    r0 = rises; s0 = stops; st0 = starts;
    recoverCmd = 1'b1;
    @(negedge clk);
    recoverCmd = 1'b0;
    extScl = 1'b0;
    // R1: SCL pulled right after the command on pulse and stop paths
    chk(sclPullLow == (kind != 2), "R1 sclPullLow after command",
        int'(sclPullLow), int'(kind != 2));
    if (extraCmd) begin
      repeat (5) @(negedge clk);
      chk(busBusy == 1'b1, "R8 busy mid sequence", int'(busBusy), 1);
      recoverCmd = 1'b1;
      @(negedge clk);
      recoverCmd = 1'b0;
    end
    w = 0;
    while (!recoverDone && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(recoverDone == 1'b1, "R6 done set at finish", int'(recoverDone), 1);
    repeat (2) @(negedge clk);
    ok = expSuccess(kind, n);
    chk(rises - r0 == expRises(kind, n),
        extraCmd ? "R9 rises with ignored command" : "R2 R3 R5 SCL rising edges",
        rises - r0, expRises(kind, n));
    chk(stops - s0 == (ok && kind != 2 ? 1 : 0), "R4 STOP count",
        stops - s0, (ok && kind != 2) ? 1 : 0);
    chk(starts == st0, "R4 no START", starts - st0, 0);
    chk(sdaLevel == ok, "R3 sdaLevel after finish", int'(sdaLevel), int'(ok));
    chk(sclLevel == 1'b1, "R8 sclLevel after finish", int'(sclLevel), 1);
    chk(busBusy == !ok, "R8 busBusy after finish", int'(busBusy), int'(!ok));
    chk(recoverDone == 1'b1, "R7 done sticky", int'(recoverDone), 1);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    chk(recoverDone == 1'b0, "R7 done cleared", int'(recoverDone), 0);
    tgtArmed = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog expired actual=hang expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(sclPullLow == 1'b0, "R10 reset sclPullLow", int'(sclPullLow), 0);
    chk(sdaPullLow == 1'b0, "R10 reset sdaPullLow", int'(sdaPullLow), 0);
    chk(recoverDone == 1'b0, "R10 reset done", int'(recoverDone), 0);
    chk(busBusy == 1'b0, "R10 reset busy", int'(busBusy), 0);

    // R8 level reporting with SCL held by another device
    extScl = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclLevel == 1'b0, "R8 sclLevel held low", int'(sclLevel), 0);
    chk(busBusy == 1'b1, "R8 busy with SCL low", int'(busBusy), 1);
    chk(sclPullLow == 1'b0, "R10 no pull when idle", int'(sclPullLow), 0);
    extScl = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclLevel == 1'b1, "R8 sclLevel released", int'(sclLevel), 1);

    // directed corners
    runTrial(2, 0, 1'b0);              // R6 both lines high
    runTrial(1, 0, 1'b0);              // R5 STOP only
    runTrial(0, 1, 1'b0);              // R2 one pulse
    runTrial(0, MAX_PULSES, 1'b0);     // R2 release on last pulse
    runTrial(0, MAX_PULSES + 1, 1'b0); // R3 failure
    runTrial(0, 3, 1'b1);              // R9 command while active

    // random mix
    for (int i = 0; i < 25; i++) begin
      int k, n;
      k = ($urandom_range(0, 5) < 4) ? 0 : int'($urandom_range(1, 2));
      n = int'($urandom_range(1, MAX_PULSES + 3));
      runTrial(k, n, (k == 0) && ($urandom_range(0, 3) == 0));
    end
    summary();
  end

endmodule